// File: doc/BRIEF.md
# Single-Cycle Harvard RISC Core

This block is a 32-bit processor core that retires one instruction on every rising clock edge. It follows a Harvard organisation. A read-only instruction port carries the program counter out and takes the instruction word back in the same cycle. A separate read/write data port serves loads and stores. Inside the core are the program counter, the next-address logic, a 32-entry register file, a sign extender, an ALU and the steering multiplexers for operands and write-back.

The supported instructions are a fixed set of eight. Register-to-register add, subtract, AND, OR and signed set-less-than share one register-format opcode and are told apart by the function field. A load word and a store word use base-plus-displacement addressing. A branch-if-equal uses a PC-relative offset counted in instruction words. The memories sit outside the core: the surrounding system, or a testbench, holds the program and data arrays and answers both ports combinationally. Instruction fetch, register reads and data reads are combinational. Register and memory writes take effect on the clock edge that ends the instruction.

Top module: `sc_cpu`

## Requirements
- R1: While the synchronous active-high reset is sampled high, the next program counter is 0, and neither the register file nor the data port (`dmem_we` low) is written.
- R2: Out of reset, every instruction other than a taken branch advances the program counter by 4 on the next rising edge.
- R3: Register-format instructions (opcode 000000, bits [31:26]) read the registers at bits [25:21] and [20:16] and write the register at bits [15:11]. The function code in bits [5:0] selects the operation: 100000 add, 100010 subtract, 100100 AND, 100101 OR.
- R4: Function code 101010 writes 1 to the destination when the first source is less than the second as signed two's-complement values, and 0 otherwise.
- R5: Load (opcode 100011) reads data at byte address rs + sign-extended bits [15:0] and writes the value to the register at bits [20:16].
- R6: Store (opcode 101011) raises `dmem_we` for one cycle, with `dmem_addr` = rs + sign-extended bits [15:0] and `dmem_wdata` = the register at bits [20:16]. No other instruction raises `dmem_we`.
- R7: Branch (opcode 000100) with equal source registers sets the next program counter to PC + 4 + (sign-extended bits [15:0] × 4). Negative offsets branch backward.
- R8: Branch with unequal source registers sets the next program counter to PC + 4.
- R9: Register 0 always reads as zero. A write that targets it has no effect.
- R10: An unrecognised opcode, an unrecognised function code, or a nonzero bits [10:6] on a register-format word writes no register and no memory, and the program counter advances by 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| imem_addr | output | 32 | Byte address of the current instruction (the PC register) |
| imem_rdata | input | 32 | Instruction word at `imem_addr` |
| dmem_addr | output | 32 | Byte address for data loads and stores |
| dmem_wdata | output | 32 | Store data |
| dmem_we | output | 1 | Store strobe; the data memory writes on the rising edge |
| dmem_rdata | input | 32 | Load data at `dmem_addr` |

## Verification
The bound checker checks the following on every cycle:
- the reset value of the program counter;
- the +4 step after every non-branch word;
- that a branch lands only on its fall-through or its target;
- that the store strobe appears only with a store opcode and never during reset;
- that a read of register 0 yields zero.

ALU results, signed comparison, load sign extension, skipped stores after a taken branch and the no-effect of illegal words leave no single-cycle signature at the ports. The bench shows them instead. It runs a program whose stores expose each result in a fixed order and whose total cycle count to reach a backward self-branch is known in advance.

// File: rtl/sc_pkg.sv
package sc_pkg;
  localparam logic [5:0] OP_REG = 6'b000000;
  localparam logic [5:0] OP_LW  = 6'b100011;
  localparam logic [5:0] OP_SW  = 6'b101011;
  localparam logic [5:0] OP_BEQ = 6'b000100;

  localparam logic [5:0] FN_ADD = 6'b100000;
  localparam logic [5:0] FN_SUB = 6'b100010;
  localparam logic [5:0] FN_AND = 6'b100100;
  localparam logic [5:0] FN_OR  = 6'b100101;
  localparam logic [5:0] FN_SLT = 6'b101010;

  typedef enum logic [2:0] {
    ALU_ADD,
    ALU_SUB,
    ALU_AND,
    ALU_OR,
    ALU_SLT
  } alu_op_e;

  typedef struct packed {
    logic    reg_we;   // write the register file
    logic    dst_rd;   // destination from bits [15:11] instead of [20:16]
    logic    src_imm;  // ALU second operand is the extended immediate
    logic    wb_mem;   // write back load data instead of ALU result
    logic    mem_we;   // store strobe
    logic    branch;   // conditional branch on equality
    alu_op_e alu_op;
  } ctrl_t;
endpackage

// File: rtl/sc_decode.sv
module sc_decode
  import sc_pkg::*;
(
  input  logic [5:0] op,
  input  logic [5:0] funct,
  input  logic [4:0] shamt,
  output ctrl_t      ctrl
);
  always_comb begin
    ctrl = '{reg_we: 1'b0, dst_rd: 1'b0, src_imm: 1'b0, wb_mem: 1'b0,
             mem_we: 1'b0, branch: 1'b0, alu_op: ALU_ADD};
    case (op)
      OP_REG: begin
        if (shamt == 5'd0) begin
          case (funct)
            FN_ADD:  begin ctrl.reg_we = 1'b1; ctrl.dst_rd = 1'b1; ctrl.alu_op = ALU_ADD; end
            FN_SUB:  begin ctrl.reg_we = 1'b1; ctrl.dst_rd = 1'b1; ctrl.alu_op = ALU_SUB; end
            FN_AND:  begin ctrl.reg_we = 1'b1; ctrl.dst_rd = 1'b1; ctrl.alu_op = ALU_AND; end
            FN_OR:   begin ctrl.reg_we = 1'b1; ctrl.dst_rd = 1'b1; ctrl.alu_op = ALU_OR;  end
            FN_SLT:  begin ctrl.reg_we = 1'b1; ctrl.dst_rd = 1'b1; ctrl.alu_op = ALU_SLT; end
            default: ;
          endcase
        end
      end
      OP_LW: begin
        ctrl.reg_we  = 1'b1;
        ctrl.src_imm = 1'b1;
        ctrl.wb_mem  = 1'b1;
      end
      OP_SW: begin
        ctrl.src_imm = 1'b1;
        ctrl.mem_we  = 1'b1;
      end
      OP_BEQ: begin
        ctrl.branch = 1'b1;
        ctrl.alu_op = ALU_SUB;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/sc_alu.sv
module sc_alu
  import sc_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic [XLEN-1:0] a,
  input  logic [XLEN-1:0] b,
  input  alu_op_e         op,
  output logic [XLEN-1:0] y,
  output logic            zero
);
  always_comb begin
    case (op)
      ALU_ADD: y = a + b;
      ALU_SUB: y = a - b;
      ALU_AND: y = a & b;
      ALU_OR:  y = a | b;
      ALU_SLT: y = ($signed(a) < $signed(b)) ? XLEN'(1) : '0;
      default: y = '0;
    endcase
  end

  assign zero = (y == '0);
endmodule

// File: rtl/sc_regfile.sv
module sc_regfile #(
  parameter int XLEN = 32,
  parameter int NREG = 32,
  localparam int AW  = $clog2(NREG)
) (
  input  logic            clk,
  input  logic            we,
  input  logic [AW-1:0]   wa,
  input  logic [XLEN-1:0] wd,
  input  logic [AW-1:0]   ra1,
  input  logic [AW-1:0]   ra2,
  output logic [XLEN-1:0] rd1,
  output logic [XLEN-1:0] rd2
);
  logic [XLEN-1:0] mem [NREG];

  // Write-only clocked process with no reset keeps the array RAM-mappable.
  always_ff @(posedge clk) begin
    if (we && (wa != '0)) begin
      mem[wa] <= wd;
    end
  end

  assign rd1 = (ra1 == '0) ? '0 : mem[ra1];
  assign rd2 = (ra2 == '0) ? '0 : mem[ra2];
endmodule

// File: rtl/sc_cpu.sv
module sc_cpu
  import sc_pkg::*;
#(
  parameter int              XLEN     = 32,
  parameter int              NREG     = 32,
  parameter logic [XLEN-1:0] RESET_PC = '0
) (
  input  logic            clk,
  input  logic            rst,
  output logic [XLEN-1:0] imem_addr,
  input  logic [31:0]     imem_rdata,
  output logic [XLEN-1:0] dmem_addr,
  output logic [XLEN-1:0] dmem_wdata,
  output logic            dmem_we,
  input  logic [XLEN-1:0] dmem_rdata
);
  localparam int AW = $clog2(NREG);

  logic [XLEN-1:0] pc;
  ctrl_t           ctrl;
  logic [AW-1:0]   rs_idx, rt_idx, rd_idx, wr_idx;
  logic [XLEN-1:0] imm_ext, rs_data, rt_data, alu_b, alu_y, wb_data;
  logic [XLEN-1:0] pc_seq, pc_br;
  logic            alu_zero, br_taken;

  assign imem_addr = pc;
  assign rs_idx    = imem_rdata[21 +: AW];
  assign rt_idx    = imem_rdata[16 +: AW];
  assign rd_idx    = imem_rdata[11 +: AW];
  assign imm_ext   = {{(XLEN-16){imem_rdata[15]}}, imem_rdata[15:0]};

  sc_decode dec_i (
    .op    (imem_rdata[31:26]),
    .funct (imem_rdata[5:0]),
    .shamt (imem_rdata[10:6]),
    .ctrl  (ctrl)
  );

  assign wr_idx  = ctrl.dst_rd ? rd_idx : rt_idx;
  assign wb_data = ctrl.wb_mem ? dmem_rdata : alu_y;

  sc_regfile #(.XLEN(XLEN), .NREG(NREG)) rf_i (
    .clk (clk),
    .we  (ctrl.reg_we & ~rst),
    .wa  (wr_idx),
    .wd  (wb_data),
    .ra1 (rs_idx),
    .ra2 (rt_idx),
    .rd1 (rs_data),
    .rd2 (rt_data)
  );

  assign alu_b = ctrl.src_imm ? imm_ext : rt_data;

  sc_alu #(.XLEN(XLEN)) alu_i (
    .a    (rs_data),
    .b    (alu_b),
    .op   (ctrl.alu_op),
    .y    (alu_y),
    .zero (alu_zero)
  );

  assign dmem_addr  = alu_y;
  assign dmem_wdata = rt_data;
  assign dmem_we    = ctrl.mem_we & ~rst;

  assign pc_seq   = pc + XLEN'(4);
  assign pc_br    = pc_seq + {imm_ext[XLEN-3:0], 2'b00};
  assign br_taken = ctrl.branch & alu_zero;

  always_ff @(posedge clk) begin
    if (rst) begin
      pc <= RESET_PC;
    end else begin
      pc <= br_taken ? pc_br : pc_seq;
    end
  end
endmodule

// File: rtl/sc_cpu_chk.sv
module sc_cpu_chk #(
  parameter int XLEN = 32
) (
  input logic            clk,
  input logic            rst,
  input logic [XLEN-1:0] imem_addr,
  input logic [5:0]      op,
  input logic [15:0]     off,
  input logic [4:0]      rs_idx,
  input logic [XLEN-1:0] rs_val,
  input logic            dmem_we
);
  logic [XLEN-1:0] br_disp;
  assign br_disp = {{(XLEN-18){off[15]}}, off, 2'b00};

  // R1: reset loads the start address
  p_reset_pc_r1: assert property (@(posedge clk) rst |=> imem_addr == '0);

  // R1: no store strobe while in reset
  p_no_store_in_reset_r1: assert property (@(posedge clk) rst |-> !dmem_we);

  // R2: every non-branch word advances by one instruction
  p_seq_pc_r2: assert property (@(posedge clk) disable iff (rst)
    (op != 6'b000100) |=> imem_addr == $past(imem_addr) + XLEN'(4));

  // R7 / R8: a branch lands on its fall-through or its target
  p_beq_pc_r7: assert property (@(posedge clk) disable iff (rst)
    (op == 6'b000100) |=> (imem_addr == $past(imem_addr) + XLEN'(4)) ||
                          (imem_addr == $past(imem_addr) + XLEN'(4) + $past(br_disp)));

  // R6: only the store opcode raises the strobe
  p_store_only_sw_r6: assert property (@(posedge clk) disable iff (rst)
    dmem_we |-> op == 6'b101011);

  // R9: register zero reads as zero
  p_x0_zero_r9: assert property (@(posedge clk) disable iff (rst)
    (rs_idx == 5'd0) |-> rs_val == '0);
endmodule

bind sc_cpu sc_cpu_chk #(.XLEN(XLEN)) chk_i (
  .clk       (clk),
  .rst       (rst),
  .imem_addr (imem_addr),
  .op        (imem_rdata[31:26]),
  .off       (imem_rdata[15:0]),
  .rs_idx    (imem_rdata[25:21]),
  .rs_val    (rs_data),
  .dmem_we   (dmem_we)
);

// File: tb/sc_cpu_tb.sv
module sc_cpu_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NSTORE     = 10;
  localparam logic [31:0] SPIN_PC = 32'd96;

  // Expected stores in program order: {address, data}
  localparam logic [63:0] EXP_STORES [NSTORE] = '{
    {32'd16, 32'h0000_0004},
    {32'd20, 32'h0000_000A},
    {32'd24, 32'h0000_0005},
    {32'd28, 32'hFFFF_FFFF},
    {32'd32, 32'h0000_0001},
    {32'd36, 32'h0000_0000},
    {32'd40, 32'h0000_0000},
    {32'd44, 32'h0000_0007},
    {32'd52, 32'hFFFF_FFFD},
    {32'd56, 32'hFFFF_FFFD}
  };
  string tags [NSTORE] = '{
    "R3 add + R5 load + R6 store", "R3 sub", "R3 and", "R3 or",
    "R4 slt signed true", "R4 slt signed false", "R9 write to reg0 ignored",
    "R5 negative displacement", "R8 not-taken falls through",
    "R10 illegal word has no effect"
  };

  logic        clk = 1'b0;
  logic        rst;
  logic [31:0] imem_addr, imem_rdata, dmem_addr, dmem_wdata, dmem_rdata;
  logic        dmem_we;
  logic [31:0] imem [32];
  logic [31:0] dmem [16];
  int          total = 0;
  int          fails = 0;
  bit          done  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sc_cpu dut_i (
    .clk        (clk),
    .rst        (rst),
    .imem_addr  (imem_addr),
    .imem_rdata (imem_rdata),
    .dmem_addr  (dmem_addr),
    .dmem_wdata (dmem_wdata),
    .dmem_we    (dmem_we),
    .dmem_rdata (dmem_rdata)
  );

  assign imem_rdata = imem[imem_addr[6:2]];
  assign dmem_rdata = dmem[dmem_addr[5:2]];
  always @(posedge clk) if (dmem_we) dmem[dmem_addr[5:2]] <= dmem_wdata;

  function automatic logic [31:0] enc_r(input logic [5:0] fn, input int rd, input int rs, input int rt);
    return {6'b000000, 5'(rs), 5'(rt), 5'(rd), 5'd0, fn};
  endfunction

  function automatic logic [31:0] enc_i(input logic [5:0] op, input int rt, input int rs, input logic [15:0] imm);
    return {op, 5'(rs), 5'(rt), imm};
  endfunction

  task automatic chk(input logic ok, input string what, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", what, act, exp);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 5000);
    if (!done) begin
      total++;
      fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    int n = 0;
    int k = 0;
    for (int i = 0; i < 32; i++) imem[i] = 32'h0;
    for (int i = 0; i < 16; i++) dmem[i] = 32'h0;
    dmem[0] = 32'd7;
    dmem[1] = 32'hFFFF_FFFD;
    imem[0]  = enc_i(6'b100011, 1, 0, 16'd0);
    imem[1]  = enc_i(6'b100011, 2, 0, 16'd4);
    imem[2]  = enc_r(6'b100000, 3, 1, 2);
    imem[3]  = enc_i(6'b101011, 3, 0, 16'd16);
    imem[4]  = enc_r(6'b100010, 4, 1, 2);
    imem[5]  = enc_i(6'b101011, 4, 0, 16'd20);
    imem[6]  = enc_r(6'b100100, 5, 1, 2);
    imem[7]  = enc_i(6'b101011, 5, 0, 16'd24);
    imem[8]  = enc_r(6'b100101, 6, 1, 2);
    imem[9]  = enc_i(6'b101011, 6, 0, 16'd28);
    imem[10] = enc_r(6'b101010, 7, 2, 1);
    imem[11] = enc_i(6'b101011, 7, 0, 16'd32);
    imem[12] = enc_r(6'b101010, 8, 1, 2);
    imem[13] = enc_i(6'b101011, 8, 0, 16'd36);
    imem[14] = enc_r(6'b100000, 0, 1, 1);
    imem[15] = enc_i(6'b101011, 0, 0, 16'd40);
    imem[16] = enc_i(6'b100011, 9, 3, 16'hFFFC);
    imem[17] = enc_i(6'b101011, 9, 0, 16'd44);
    imem[18] = enc_i(6'b000100, 9, 1, 16'd1);
    imem[19] = enc_i(6'b101011, 1, 0, 16'd48);
    imem[20] = enc_i(6'b000100, 2, 1, 16'd5);
    imem[21] = enc_i(6'b101011, 2, 0, 16'd52);
    imem[22] = 32'hFC22_0000;
    imem[23] = enc_i(6'b101011, 2, 0, 16'd56);
    imem[24] = enc_i(6'b000100, 0, 0, 16'hFFFF);

    rst = 1'b1;
    repeat (3) @(negedge clk);
    chk(imem_addr == 32'd0, "R1 pc in reset", imem_addr, 32'd0);
    chk(dmem_we == 1'b0, "R1 no store in reset", 32'(dmem_we), 32'd0);
    rst = 1'b0;

    // Walk the program; each observed store is matched against the table.
    while (imem_addr != SPIN_PC && n < 60) begin
      if (dmem_we) begin
        if (k < NSTORE) begin
          chk(dmem_addr == EXP_STORES[k][63:32], {tags[k], " addr"}, dmem_addr, EXP_STORES[k][63:32]);
          chk(dmem_wdata == EXP_STORES[k][31:0], {tags[k], " data"}, dmem_wdata, EXP_STORES[k][31:0]);
        end else begin
          chk(1'b0, "R7 unexpected extra store", dmem_addr, 32'd0);
        end
        k++;
      end
      @(negedge clk);
      n++;
    end

    chk(n == 23, "R2/R7/R8 cycles to reach spin loop", 32'(n), 32'd23);
    chk(k == NSTORE, "R7 taken branch skipped a store", 32'(k), 32'(NSTORE));

    repeat (4) @(negedge clk);
    chk(imem_addr == SPIN_PC, "R7 backward branch to self", imem_addr, SPIN_PC);
    chk(dmem_we == 1'b0, "R6 branch raises no strobe", 32'(dmem_we), 32'd0);

    rst = 1'b1;
    @(negedge clk);
    chk(imem_addr == 32'd0, "R1 mid-run reset", imem_addr, 32'd0);
    chk(dmem_we == 1'b0, "R1 strobe low in reset", 32'(dmem_we), 32'd0);
    rst = 1'b0;
    @(negedge clk);
    chk(imem_addr == 32'd4, "R2 first step after reset", imem_addr, 32'd4);
    chk(dmem[4] == 32'd4, "R6 stored word landed in memory", dmem[4], 32'd4);
    chk(dmem[12] == 32'd0, "R7 skipped address untouched", dmem[12], 32'd0);

    done = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule